// File: doc/BRIEF.md
# Power-Fail Supervisor and Reset Sequencer

This controller sits beside a battery-backed static memory and decides, from two
synchronized comparator flags, when that memory may be accessed. One flag reports
that the supply is under the power-fail level. The other reports that it is under
a lower switchover level. When the supply fails, the memory is deselected and
write-protected and the system reset is pulled low. When the supply falls further,
the memory is powered from the battery instead of the external rail.

The power-fail flag is filtered over a programmable number of consecutive samples,
so short noise spikes are ignored. A single recovery counter then holds both
deselect and reset for a fixed number of cycles after the filtered flag clears. It
restarts from zero if the supply fails again during the count. A write guard stands
between the host write strobe and the memory. It passes a write only while the
memory is enabled. It freezes the address of a write already in progress, and it
cuts that write off at once when deselect rises, so only the addressed word can be
damaged. A sampled combination of flags that cannot occur raises an error bit.

Top module: `pwr_supervisor`

## Requirements
- R1: After the power-fail input has read 1 on DEB_N consecutive clock edges, deselect_o is 1 after that edge, and it stays 1 while the filtered fail condition holds.
- R2: batt_sel_o (1 = battery, 0 = external supply) equals the switchover input sampled at the previous clock edge.
- R3: When the power-fail input reads 0 from a settled fail state and stays 0, deselect_o first reads 0 after clock edge DEB_N+REC_N, counted from the first edge that samples the 0.
- R4: rst_out_n is 0 whenever the filtered fail condition holds. This includes the case where both the power-fail input and the switchover input are 1.
- R5: rst_out_n rises in the same cycle that deselect_o falls, and rst_out_n always equals the inverse of deselect_o.
- R6: If the filtered fail condition returns during the recovery count, the count restarts from zero. Release then comes REC_N edges after the filtered condition clears again.
- R7: A run of fewer than DEB_N consecutive samples that differ from the filtered power-fail state has no effect on deselect_o or rst_out_n. A longer low pulse lets deselect_o fall for exactly L-REC_N cycles when L >= REC_N and L >= DEB_N. A high pulse of H >= DEB_N cycles holds deselect_o high for H+REC_N cycles.
- R8: err_o is 1 after an edge that sampled switchover input = 1 while the power-fail input = 0, and it is 0 after any other sample.
- R9: While rst_n is 0 at a clock edge, the outputs after that edge are deselect_o = 1, rst_out_n = 0, batt_sel_o = 1, err_o = 0 and mem_we_o = 0.
- R10: mem_we_o equals wr_req_i for a write that began while deselect_o was 0. mem_we_o drops to 0 in the cycle deselect_o rises. mem_addr_o holds the address that was present when the write began, for as long as wr_req_i stays 1.
- R11: A write strobe that is held through a deselect period, or that began during one, never drives mem_we_o. A new write is passed only after wr_req_i has been 0 for at least one clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_below_i | input | 1 | Supply under power-fail level (synchronized) |
| so_below_i | input | 1 | Supply under switchover level (synchronized) |
| wr_req_i | input | 1 | Host write strobe, held high for the write cycle |
| wr_addr_i | input | AW | Host write address |
| deselect_o | output | 1 | Memory deselect / write protect, 1 = protected |
| rst_out_n | output | 1 | System reset, active low |
| batt_sel_o | output | 1 | Power source, 1 = battery, 0 = external |
| err_o | output | 1 | Impossible flag combination seen |
| mem_we_o | output | 1 | Gated write enable to the memory |
| mem_addr_o | output | AW | Address to the memory, frozen during a write |

## Verification
Several rules are checked on every cycle. The filtered flag may change only after a full run of DEB_N differing samples. The recovery counter returns to zero after any filtered fail. Release happens only at the end of a complete count, and the memory address stays frozen while a write is in progress. The exact release cycle, the length of release pulses caused by short low or high inputs, the restart case and the write cut-off and re-arm order can be shown only by the bench's pulse-length sweeps and its directed sequences.

// File: rtl/pwr_sup_pkg.sv
// Package: shared types for the power-fail supervisor.
// Assumes: nothing beyond IEEE 1800-2017.
package pwr_sup_pkg;

    // Write guard state: idle, write passing, write blocked until strobe drops.
    typedef enum logic [1:0] {
        WG_IDLE  = 2'd0,
        WG_WRITE = 2'd1,
        WG_BLOCK = 2'd2
    } wg_state_t;

    // Width helper: bits needed to hold values 0..n.
    function automatic int cnt_bits(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/pf_debounce.sv
// Module: pf_debounce
// Filters the power-fail flag. The filtered output takes a new value only after
// DEB_N consecutive samples that disagree with it. Any agreeing sample clears
// the run. Assumes the input is already synchronized to clk. After reset the
// filtered value reads "failing".
module pf_debounce
    import pwr_sup_pkg::*;
#(
    parameter int DEB_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    localparam int RW = cnt_bits(DEB_N);
    localparam logic [RW-1:0] RUN_LAST = RW'(DEB_N - 1);

    logic [RW-1:0] run_q;
    logic          filt_q;

    // Count disagreeing samples and flip the filtered value at the end of a full run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            filt_q <= 1'b1;
        end else if (raw_i != filt_q) begin
            if (run_q == RUN_LAST) begin
                filt_q <= raw_i;
                run_q  <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign filt_o = filt_q;

    // R7: the filtered value changes only after a complete disagreeing run.
    p_full_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_q != $past(filt_q)) |-> ($past(run_q) == RUN_LAST));

endmodule

// File: rtl/rec_timer.sv
// Module: rec_timer
// Recovery counter shared by deselect and reset. While the filtered fail flag is
// set, the count is held at zero. Once the flag clears, the counter runs for
// REC_N edges and then marks the supply as ready. A new fail restarts it.
// Assumes fail_i comes from a register.
module rec_timer
    import pwr_sup_pkg::*;
#(
    parameter int REC_N = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_i,
    output logic ready_o
);
    localparam int CW = cnt_bits(REC_N);
    localparam logic [CW-1:0] CNT_LAST = CW'(REC_N - 1);

    logic [CW-1:0] cnt_q;
    logic          ready_q;

    // Clear on fail, count up otherwise, and latch ready at the final count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (fail_i) begin
            cnt_q   <= '0;
            ready_q <= 1'b0;
        end else if (!ready_q) begin
            if (cnt_q == CNT_LAST) begin
                ready_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign ready_o = ready_q;

    // R6: any fail sample restarts the count from zero.
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fail_i |=> (cnt_q == '0) && !ready_q);

    // R3: ready appears only at the end of a full count with no fail.
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_q) |-> ($past(cnt_q) == CNT_LAST) && !$past(fail_i));

endmodule

// File: rtl/src_select.sv
// Module: src_select
// Chooses the power source from the switchover flag and reports the impossible
// case: under switchover but not under power-fail. Battery is selected from
// reset until the first sample. Assumes both flags are synchronized.
module src_select (
    input  logic clk,
    input  logic rst_n,
    input  logic pf_below_i,
    input  logic so_below_i,
    output logic batt_sel_o,
    output logic err_o
);
    logic batt_q;
    logic err_q;

    // Register source choice and error status each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            batt_q <= 1'b1;
            err_q  <= 1'b0;
        end else begin
            batt_q <= so_below_i;
            err_q  <= so_below_i & ~pf_below_i;
        end
    end

    assign batt_sel_o = batt_q;
    assign err_o      = err_q;

endmodule

// File: rtl/write_guard.sv
// Module: write_guard
// Gates the host write strobe. A write that starts while the memory is enabled
// passes, with its address frozen. Deselect ends it at once. A strobe seen under
// deselect is blocked until it drops. Assumes one write per strobe high period.
module write_guard
    import pwr_sup_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          deselect_i,
    input  logic          wr_req_i,
    input  logic [AW-1:0] wr_addr_i,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o
);
    wg_state_t     st_q;
    logic [AW-1:0] addr_q;

    // Track the write cycle and latch its address on entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= WG_IDLE;
            addr_q <= '0;
        end else begin
            case (st_q)
                WG_IDLE: begin
                    addr_q <= wr_addr_i;
                    if (wr_req_i) st_q <= deselect_i ? WG_BLOCK : WG_WRITE;
                end
                WG_WRITE: begin
                    if (!wr_req_i)      st_q <= WG_IDLE;
                    else if (deselect_i) st_q <= WG_BLOCK;
                end
                WG_BLOCK: begin
                    if (!wr_req_i) st_q <= WG_IDLE;
                end
                default: st_q <= WG_IDLE;
            endcase
        end
    end

    // Drive the memory-side strobe and address.
    always_comb begin
        mem_we_o   = wr_req_i && !deselect_i && (st_q != WG_BLOCK);
        mem_addr_o = (st_q == WG_IDLE) ? wr_addr_i : addr_q;
    end

    // R10: address stays frozen across an ongoing write cycle.
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != WG_IDLE) && ($past(st_q) != WG_IDLE) |-> $stable(mem_addr_o));

endmodule

// File: rtl/pwr_supervisor.sv
// Module: pwr_supervisor (top)
// Power-fail supervisor for a battery-backed memory. It filters the power-fail
// flag and runs one recovery timer that releases deselect and reset together.
// It selects battery or external power from the lower switchover flag, and it
// guards the write strobe. Assumes both flags are synchronized to clk.
module pwr_supervisor
    import pwr_sup_pkg::*;
#(
    parameter int DEB_N = 4,
    parameter int REC_N = 10,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pf_below_i,
    input  logic          so_below_i,
    input  logic          wr_req_i,
    input  logic [AW-1:0] wr_addr_i,
    output logic          deselect_o,
    output logic          rst_out_n,
    output logic          batt_sel_o,
    output logic          err_o,
    output logic          mem_we_o,
    output logic [AW-1:0] mem_addr_o
);
    logic pf_filt;
    logic sup_ready;
    logic desel;

    pf_debounce #(.DEB_N(DEB_N)) deb_i (
        .clk(clk), .rst_n(rst_n), .raw_i(pf_below_i), .filt_o(pf_filt)
    );

    rec_timer #(.REC_N(REC_N)) rec_i (
        .clk(clk), .rst_n(rst_n), .fail_i(pf_filt), .ready_o(sup_ready)
    );

    src_select src_i (
        .clk(clk), .rst_n(rst_n), .pf_below_i(pf_below_i), .so_below_i(so_below_i),
        .batt_sel_o(batt_sel_o), .err_o(err_o)
    );

    // Protect while failing or until the recovery count completes.
    always_comb begin
        desel = pf_filt || !sup_ready;
    end

    assign deselect_o = desel;
    assign rst_out_n  = !desel;

    write_guard #(.AW(AW)) wg_i (
        .clk(clk), .rst_n(rst_n), .deselect_i(desel), .wr_req_i(wr_req_i),
        .wr_addr_i(wr_addr_i), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o)
    );

    // R1: the filtered fail state never leaves the memory enabled.
    p_fail_protect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pf_filt |-> deselect_o && !mem_we_o);

endmodule

// File: tb/pwr_supervisor_tb_top.sv
module pwr_supervisor_tb_top;
    localparam int DEB_N = 3;
    localparam int REC_N = 6;
    localparam int AW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pf = 1'b1;
    logic          so = 1'b1;
    logic          wr = 1'b0;
    logic [AW-1:0] wa = '0;
    logic          desel, rout_n, batt, err, we;
    logic [AW-1:0] ma;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    pwr_supervisor #(.DEB_N(DEB_N), .REC_N(REC_N), .AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pf_below_i(pf), .so_below_i(so),
        .wr_req_i(wr), .wr_addr_i(wa), .deselect_o(desel), .rst_out_n(rout_n),
        .batt_sel_o(batt), .err_o(err), .mem_we_o(we), .mem_addr_o(ma)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock edge, then settle before the next observation.
    task automatic tick();
        @(posedge clk);
        #1;
        cyc++;
    endtask

    task automatic settle_fail();
        pf = 1'b1;
        for (int i = 0; i < DEB_N + 2; i++) tick();
    endtask

    task automatic settle_ready();
        pf = 1'b0;
        for (int i = 0; i < DEB_N + REC_N + 2; i++) tick();
    endtask

    initial begin
        while (cyc < 100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected 0", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lo_cnt;
        int hi_cnt;
        // R9: reset state
        pf = 1'b0; so = 1'b0;
        for (int i = 0; i < 3; i++) tick();
        chk("R9 deselect", desel, 1);
        chk("R9 rst_out_n", rout_n, 0);
        chk("R9 batt_sel", batt, 1);
        chk("R9 err", err, 0);
        chk("R9 we", we, 0);
        rst_n = 1'b1;
        // R3/R5: release exactly DEB_N+REC_N edges after reset ends with pf low
        for (int e = 1; e <= DEB_N + REC_N; e++) begin
            tick();
            if (e == 1) chk("R2 external after first sample", batt, 0);
            if (e == DEB_N) chk("R1 still protected at filter edge", desel, 1);
            if (e == DEB_N + REC_N - 1) begin
                chk("R3 held one before release", desel, 1);
                chk("R5 reset held with deselect", rout_n, 0);
            end
        end
        chk("R3 released on time", desel, 0);
        chk("R5 reset released same cycle", rout_n, 1);

        // R8: error flag
        so = 1'b1; tick();
        chk("R8 err on switch-without-fail", err, 1);
        chk("R2 battery follows flag", batt, 1);
        so = 1'b0; tick();
        chk("R8 err clears", err, 0);
        chk("R2 external again", batt, 0);

        // R4: both flags set (supply at ground)
        pf = 1'b1; so = 1'b1;
        for (int i = 0; i < DEB_N; i++) tick();
        chk("R4 reset low at ground", rout_n, 0);
        chk("R4 deselect at ground", desel, 1);
        chk("R8 no err when both set", err, 0);
        chk("R2 battery at ground", batt, 1);
        so = 1'b0;
        settle_fail();

        // R7/R3: low-pulse sweep from settled fail
        for (int L = 1; L <= DEB_N + REC_N + 3; L++) begin
            settle_fail();
            lo_cnt = 0; hi_cnt = 0;
            pf = 1'b0;
            for (int e = 1; e <= L + DEB_N + REC_N + 4; e++) begin
                tick();
                if (desel == 1'b0) lo_cnt++;
                if (rout_n == 1'b1) hi_cnt++;
                if (e == L) pf = 1'b1;
            end
            chk($sformatf("R7 low pulse %0d release cycles", L), lo_cnt,
                (L >= REC_N && L >= DEB_N) ? L - REC_N : 0);
            chk($sformatf("R5 low pulse %0d reset cycles", L), hi_cnt,
                (L >= REC_N && L >= DEB_N) ? L - REC_N : 0);
        end

        // R7/R1: high-pulse sweep from settled ready
        for (int H = 1; H <= DEB_N + 5; H++) begin
            settle_ready();
            lo_cnt = 0;
            pf = 1'b1;
            for (int e = 1; e <= H + DEB_N + REC_N + 4; e++) begin
                tick();
                if (desel == 1'b1) lo_cnt++;
                if (e == H) pf = 1'b0;
            end
            chk($sformatf("R7 high pulse %0d protected cycles", H), lo_cnt,
                (H >= DEB_N) ? H + REC_N : 0);
        end

        // R6: fail returns during recovery
        settle_fail();
        pf = 1'b0;
        for (int e = 1; e <= DEB_N + 3 + 2 * DEB_N + REC_N; e++) begin
            tick();
            if (e == DEB_N + 3) pf = 1'b1;
            if (e == 2 * DEB_N + 3) pf = 1'b0;
            if (e == DEB_N + REC_N) chk("R6 no release at first schedule", desel, 1);
            if (e == 3 * DEB_N + 3 + REC_N - 1) chk("R6 held until restarted count ends", desel, 1);
        end
        chk("R6 released after restarted count", desel, 0);

        // R10/R11: write guard
        settle_ready();
        wa = 8'h5A; wr = 1'b1;
        #1;
        chk("R10 write passes when enabled", we, 1);
        chk("R10 address passes", ma, 8'h5A);
        tick();
        wa = 8'hC3;
        #1;
        chk("R10 address frozen", ma, 8'h5A);
        chk("R10 write still on", we, 1);
        pf = 1'b1;
        for (int e = 1; e <= DEB_N; e++) begin
            tick();
            if (e == DEB_N - 1) chk("R10 write on before deselect", we, 1);
        end
        chk("R10 write cut at deselect", we, 0);
        chk("R10 address frozen in block", ma, 8'h5A);
        pf = 1'b0;
        for (int e = 1; e <= DEB_N + REC_N + 2; e++) tick();
        chk("R11 enabled again", desel, 0);
        chk("R11 held strobe stays blocked", we, 0);
        wr = 1'b0; tick();
        wr = 1'b1; #1;
        chk("R11 new write passes", we, 1);
        chk("R10 new address passes", ma, 8'hC3);
        tick();
        wr = 1'b0;
        // R11: strobe started during deselect is blocked after release
        pf = 1'b1;
        for (int e = 0; e < DEB_N; e++) tick();
        wr = 1'b1; tick();
        pf = 1'b0;
        for (int e = 0; e < DEB_N + REC_N + 2; e++) tick();
        chk("R11 strobe from deselect blocked", we, 0);
        wr = 1'b0; tick();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule